// File: doc/BRIEF.md
# Two-Strobe Transmit Word Queue

This block sits between a 16-bit host write port and a serial line transmitter. The host builds each 31-bit transmit word in two writes. A first-half strobe captures the low sixteen bits. A second-half strobe supplies the upper fifteen bits and completes the word. Completed words enter an eight-entry first-in first-out store.

The oldest stored word is always presented to the serializer together with a valid flag. The serializer removes that word by raising its take input. A registered ready flag tells the host that nothing is left to send. The flag rises once every loaded word has been taken. It does not report free space.

Reset is synchronous and active low. It empties the store, raises the ready flag and discards any half-built word.

Top module: `tx_word_queue`

## Requirements
- R1: While `rst_n` is low at a clock edge, the queue becomes empty after that edge: `tx_ready` = 1, `word_valid` = 0, and any captured first half is discarded.
- R2: A completed word carries the first-half write's `host_data[15:0]` in bits 15:0 and the second-half write's `host_data[14:0]` in bits 30:16; `host_data[15]` at the second-half write has no effect.
- R3: A word completed at a clock edge becomes visible at the outputs after that edge (if the queue was empty) and words leave in the order they were completed.
- R4: The queue holds at most eight words; a word completed while eight are held and none is taken that cycle is discarded and the stored words are unchanged.
- R5: A second-half strobe with no first half captured since the last completed word (or reset) is ignored and queues nothing.
- R6: When several first-half strobes arrive before the second half, the most recent first half is used.
- R7: `word_valid` is high exactly when at least one word is held, `word_data` shows the oldest word, a word is removed at an edge where `word_take` and `word_valid` are both high, and `word_take` while empty has no effect.
- R8: When eight words are held and a word completes in the same cycle as a take, only the take happens; with fewer than eight held, both happen and the number held is unchanged.
- R9: `tx_ready` is high exactly when no word is held; it rises at the edge that removes the last word and falls at the edge that queues a word into an empty queue.
- R10: When both strobes are high in one cycle, the second half completes the word whose first half was captured earlier (if any), and the current `host_data[15:0]` is captured as the first half of the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_first | input | 1 | First-half strobe: captures bits 15:0 |
| ld_second | input | 1 | Second-half strobe: supplies bits 30:16 and completes the word |
| host_data | input | 16 | Host write data |
| word_valid | output | 1 | A word is held and presented |
| word_data | output | 31 | Oldest held word |
| word_take | input | 1 | Serializer accepts the presented word |
| tx_ready | output | 1 | High when no word is held |

## Verification
The bench fills the queue to eight words and keeps writing. A design that let those writes through would overwrite the oldest entry or wrap its pointers, and the drain that follows would show the wrong words or the wrong count. It also completes a word and takes one in the same cycle, at full and at partial occupancy. Getting the precedence wrong shows up as a lost word or a ninth entry. Lone second-half strobes, repeated first halves and both strobes in one cycle each check the assembly state. A stray push or a stale half shows up as an extra or corrupted word. Random traffic checks the ready flag on every cycle, so a flag that tracks free space instead of emptiness fails quickly.

// File: rtl/txq_pkg.sv
// Shared sizes for the two-strobe transmit word queue.
package txq_pkg;
    localparam int HALF_W  = 16;   // host bus width
    localparam int WORD_W  = 31;   // assembled word width
    localparam int DEPTH   = 8;    // words held
endpackage

// File: rtl/txq_half_assembler.sv
// Builds a word from two ordered host writes.
// Assumes: first half on ld_first, upper bits on ld_second from data[HI_W-1:0].
// A second half without a captured first half produces no push.
module txq_half_assembler #(
    parameter int HALF_W = 16,
    parameter int WORD_W = 31,
    localparam int HI_W  = WORD_W - HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_first,
    input  logic              ld_second,
    input  logic [HALF_W-1:0] host_data,
    output logic              push_req,
    output logic [WORD_W-1:0] push_word
);
    logic              armed_q;
    logic [HALF_W-1:0] low_q;

    // Complete a word when the upper half meets a captured lower half.
    always_comb begin
        push_req  = ld_second && armed_q;
        push_word = {host_data[HI_W-1:0], low_q};
    end

    // Track the captured lower half; a new first half re-arms after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            low_q   <= '0;
        end else begin
            if (ld_second) armed_q <= 1'b0;
            if (ld_first) begin
                armed_q <= 1'b1;
                low_q   <= host_data;
            end
        end
    end

    // R6
    lo_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_first |=> (armed_q && low_q == $past(host_data)));
    // R5
    lone_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_second && !ld_first) |=> !armed_q);
endmodule

// File: rtl/txq_occupancy.sv
// Counts held words, decides which requests take effect and keeps the ready flag.
// Assumes push_req and pop_req are single-cycle requests evaluated each edge.
// When full, a pop wins and a simultaneous push is dropped.
module txq_occupancy #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_req,
    input  logic pop_req,
    output logic push_ok,
    output logic pop_ok,
    output logic empty_q
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             full;

    // Accept decisions and next count.
    always_comb begin
        full    = (cnt_q == CNT_W'(DEPTH));
        pop_ok  = pop_req && !empty_q;
        push_ok = push_req && !full;
        cnt_d   = cnt_q;
        if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
        if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    end

    // Register the count and the emptiness flag together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            empty_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_d;
            empty_q <= (cnt_d == '0);
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req) |=> (cnt_q == CNT_W'(DEPTH)));
    // R8
    full_pop_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && pop_req) |=> (cnt_q == CNT_W'(DEPTH - 1)));
    // R9
    last_pop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(1) && pop_req && !push_req) |=> empty_q);
    // R9
    push_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> !empty_q);
endmodule

// File: rtl/txq_ring_store.sv
// Circular word storage with separate read and write pointers.
// Assumes the caller only asserts wr_en/rd_en when accepted by the occupancy logic.
module txq_ring_store #(
    parameter int WORD_W = 31,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word
);
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [WORD_W-1:0] slot_q [DEPTH];

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Move the pointers on accepted writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (wr_en) wr_ptr_q <= step_ptr(wr_ptr_q);
            if (rd_en) rd_ptr_q <= step_ptr(rd_ptr_q);
        end
    end

    // One storage slot per entry, written only when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr_q == PTR_W'(g)) slot_q[g] <= wr_word;
        end
    end

    // Present the oldest entry.
    always_comb rd_word = slot_q[rd_ptr_q];

    // R7
    hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !(wr_en && wr_ptr_q == rd_ptr_q)) |=> $stable(rd_word));
endmodule

// File: rtl/tx_word_queue.sv
// Top: two-strobe assembly into an eight-word queue feeding a serializer.
// Assumes synchronous active-low reset and a serializer that takes on word_take.
module tx_word_queue
    import txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_first,
    input  logic              ld_second,
    input  logic [HALF_W-1:0] host_data,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    input  logic              word_take,
    output logic              tx_ready
);
    logic              push_req;
    logic [WORD_W-1:0] push_word;
    logic              push_ok;
    logic              pop_ok;
    logic              empty_q;

    txq_half_assembler #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .ld_first(ld_first), .ld_second(ld_second),
        .host_data(host_data), .push_req(push_req), .push_word(push_word)
    );

    txq_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(word_take),
        .push_ok(push_ok), .pop_ok(pop_ok), .empty_q(empty_q)
    );

    txq_ring_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_word(push_word),
        .rd_en(pop_ok), .rd_word(word_data)
    );

    // Output flags follow the registered emptiness.
    always_comb begin
        tx_ready   = empty_q;
        word_valid = !empty_q;
    end

    // R1
    reset_ready_chk: assert property (@(posedge clk)
        !rst_n |=> (tx_ready && !word_valid));
    // R7
    take_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !push_req) |=> tx_ready);
endmodule

// File: tb/tb_tx_word_queue.sv
`timescale 1ns/1ps
module tb_tx_word_queue;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_first, ld_second, word_take;
    logic [15:0] host_data;
    logic        word_valid, tx_ready;
    logic [30:0] word_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    logic [30:0] mq [8];
    int          mcnt = 0;
    bit          mpend = 1'b0;
    logic [15:0] mlo = '0;

    always #2 clk = ~clk;

    tx_word_queue dut (
        .clk(clk), .rst_n(rst_n), .ld_first(ld_first), .ld_second(ld_second),
        .host_data(host_data), .word_valid(word_valid), .word_data(word_data),
        .word_take(word_take), .tx_ready(tx_ready)
    );

    function automatic logic [30:0] make_word(input logic [15:0] lo, input logic [15:0] hi);
        return {hi[14:0], lo};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        mcnt = 0; mpend = 1'b0; mlo = '0;
    endtask

    // apply one cycle of stimulus, update model, compare outputs
    task automatic step(input string tag, input bit lo, input bit hi,
                        input logic [15:0] d, input bit take);
        bit take_eff, push;
        logic [30:0] w;
        @(negedge clk);
        ld_first = lo; ld_second = hi; host_data = d; word_take = take;
        @(posedge clk);
        take_eff = take && (mcnt > 0);
        push = hi && mpend;
        w = make_word(mlo, d);
        if (take_eff) begin
            for (int i = 0; i < 7; i++) mq[i] = mq[i+1];
            mcnt--;
            if (push && mcnt == 7) push = 1'b0;   // was full: pop wins
        end
        if (push && mcnt < 8) begin
            mq[mcnt] = w;
            mcnt++;
        end
        if (hi) mpend = 1'b0;
        if (lo) begin mpend = 1'b1; mlo = d; end
        #1;
        check({tag, " ready"}, 32'(tx_ready), 32'(mcnt == 0));
        check({tag, " valid"}, 32'(word_valid), 32'(mcnt > 0));
        if (mcnt > 0) check({tag, " data"}, 32'(word_data), 32'(mq[0]));
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, 16'h0, 1'b0);
    endtask

    task automatic put(input string tag, input logic [15:0] lo, input logic [15:0] hi);
        step(tag, 1'b1, 1'b0, lo, 1'b0);
        step(tag, 1'b0, 1'b1, hi, 1'b0);
    endtask

    task automatic drain(input string tag);
        while (mcnt > 0) step(tag, 1'b0, 1'b0, 16'h0, 1'b1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357));
        rst_n = 1'b0; ld_first = 0; ld_second = 0; word_take = 0; host_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        #0;
        check("R1 ready", 32'(tx_ready), 32'd1);
        check("R1 valid", 32'(word_valid), 32'd0);

        // R5: lone second half after reset
        step("R5", 1'b0, 1'b1, 16'h1234, 1'b0);
        idle("R5");

        // R2: bit 15 of upper write ignored; R3 visible next edge
        put("R2", 16'hA5A5, 16'hFFFF);
        check("R2 word", 32'(word_data), 32'(31'h7FFF_A5A5));
        drain("R9");

        // R6: repeated first halves
        step("R6", 1'b1, 1'b0, 16'h1111, 1'b0);
        step("R6", 1'b1, 1'b0, 16'h2222, 1'b0);
        step("R6", 1'b0, 1'b1, 16'h0003, 1'b0);
        check("R6 word", 32'(word_data), 32'({15'h3, 16'h2222}));

        // R10: both strobes in one cycle
        step("R10", 1'b1, 1'b0, 16'h00AA, 1'b0);
        step("R10", 1'b1, 1'b1, 16'h00BB, 1'b0);
        step("R10", 1'b0, 1'b1, 16'h0005, 1'b0);
        drain("R10");

        // R4 / R3: fill past capacity then drain in order
        for (int i = 0; i < 10; i++) put("R4", 16'(i * 16'h0101), 16'(i + 1));
        check("R4 count-full ready", 32'(tx_ready), 32'd0);
        drain("R3");

        // R8: full with simultaneous push and pop
        for (int i = 0; i < 8; i++) put("R8", 16'(16'h4000 + i), 16'(i));
        step("R8", 1'b1, 1'b0, 16'hBEEF, 1'b0);
        step("R8", 1'b0, 1'b1, 16'h0042, 1'b1);
        step("R8", 1'b1, 1'b0, 16'hCAFE, 1'b0);
        step("R8", 1'b0, 1'b1, 16'h0043, 1'b1);
        drain("R8");

        // R7: take while empty
        step("R7", 1'b0, 1'b0, 16'h0, 1'b1);
        step("R7", 1'b0, 1'b0, 16'h0, 1'b1);

        // R1: reset discards a captured half and held words
        put("R1", 16'h7777, 16'h1);
        step("R1", 1'b1, 1'b0, 16'h8888, 1'b0);
        @(negedge clk); rst_n = 1'b0; ld_first = 0; ld_second = 0; word_take = 0;
        @(negedge clk); rst_n = 1'b1; model_reset();
        check("R1 ready", 32'(tx_ready), 32'd1);
        step("R1", 1'b0, 1'b1, 16'h0009, 1'b0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            automatic logic [31:0] r = $urandom;
            step("R7 rand", r[0] & r[1], r[2] & r[3], r[31:16], r[4] & r[5] & r[6]);
        end
        drain("R9 rand");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule